// File: doc/BRIEF.md
# Trap and Subroutine Control-Transfer Unit

This unit decodes 16-bit control-transfer words that enter or leave subroutines and system service routines. For each one it works out the next program counter and the write to the link register. A host pipeline presents an instruction together with the already incremented PC. The unit selects a register-file read port for itself, and it drives a read request into a low-memory vector table when a service call needs one. The calling pipeline applies the `pcWe`/`nextPc` and `linkWe`/`linkData` strobes at the next clock edge. Register 7 is always the link register.

There are four forms. A PC-relative call and a register-indirect call both save the return address into the link register and then jump. A return jumps back through the link register. A service call (trap) saves the return address, fetches the routine address from a 256-entry table at the bottom of memory, and then jumps to it. Every other encoding is flagged as illegal and has no effect.

Top module: `ctrl_xfer_unit`

## Requirements
- R1: A PC-relative call is a word with bits 15:12 = 0100 and bit 11 = 1. In the same cycle it drives `pcWe`=1 with `nextPc` = `pcInc` + the sign-extended bits 10:0 (modulo 2^16).
- R2: A register call is a word with bits 15:11 = 01000, bits 10:9 = 00 and bits 5:0 = 0. It drives `regRdAddr` = bits 8:6 and, in the same cycle, `pcWe`=1 with `nextPc` = `regRdData`.
- R3: Both call forms and the first cycle of a trap drive `linkWe`=1 with `linkData` = `pcInc`. A return does not write the link register.
- R4: A return is exactly 16'hC1C0. It drives `regRdAddr`=7 and `pcWe`=1 with `nextPc` = `regRdData`.
- R5: A trap is a word with bits 15:8 = 8'hF0 and the vector in bits 7:0. In its first cycle it drives `memRdReq`=1 with `memRdAddr` = the zero-extended vector and `pcWe`=0. In the following cycle `busy`=1 and `pcWe`=1 with `nextPc` = `memRdData`, which memory returns one cycle after the request.
- R6: While `busy` is 1, `instrValid` and `instr` are ignored. No link write, memory request or illegal flag arises from them.
- R7: A register call naming register 7 jumps to the value register 7 held before the link write of that same call.
- R8: A valid word that matches none of the forms above drives `illegal`=1 with `pcWe`, `linkWe` and `memRdReq` all 0.
- R9: After reset, `busy` is 0. With `instrValid` at 0 the unit drives no `pcWe`, `linkWe`, `memRdReq` or `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| pcInc | input | 16 | Incremented PC of the presented instruction |
| regRdData | input | 16 | Register-file data for `regRdAddr` |
| memRdData | input | 16 | Vector-table word, one cycle after the request |
| regRdAddr | output | 3 | Register-file read index |
| memRdReq | output | 1 | Vector-table read request |
| memRdAddr | output | 16 | Vector-table read address |
| pcWe | output | 1 | Load `nextPc` into the PC at the next edge |
| nextPc | output | 16 | New PC value |
| linkWe | output | 1 | Write `linkData` into register 7 at the next edge |
| linkData | output | 16 | Return address for the link register |
| illegal | output | 1 | Presented word is not a recognised transfer |
| busy | output | 1 | Second cycle of a trap is in progress |

## Verification
The stimulus mixes well-formed calls, returns and traps, each with random fields and random incremented PCs, with raw random words. The random words mostly land on the illegal path and separate the strict field checks from loose opcode matching. Directed cases cover the extreme relative offsets, which expose sign-extension mistakes, and the lowest and highest trap vectors, which expose address-width errors. Further directed cases cover a register call through register 7, which shows whether the old or the new link value is used, and near-miss encodings of the return and trap forms. Random words presented during the second trap cycle show whether that cycle truly ignores its inputs.

// File: rtl/ctu_pkg.sv
`timescale 1ns/1ps
package ctu_pkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 16;
  localparam int OFF_W   = 11;
  localparam int VEC_W   = 8;
  localparam int RIDX_W  = 3;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0]  OPC_CALL = 4'b0100;
  localparam logic [OPC_W-1:0]  OPC_JMP  = 4'b1100;
  localparam logic [OPC_W-1:0]  OPC_TRAP = 4'b1111;
  localparam logic [RIDX_W-1:0] LINK_REG = 3'd7;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_REG = 2'd1,
    TGT_VEC = 2'd2
  } tgtSel_e;

  typedef enum logic {
    ST_IDLE     = 1'b0,
    ST_VEC_WAIT = 1'b1
  } ctuState_e;

  typedef struct packed {
    logic    pcWe;
    logic    linkWe;
    logic    memReq;
    logic    illegal;
    tgtSel_e tgtSel;
  } xferStrobe_t;
endpackage

// File: rtl/ctu_control.sv
`timescale 1ns/1ps
module ctu_control
  import ctu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  output xferStrobe_t        strobe,
  output logic               busy
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  ctuState_e state, stateNext;
  logic [OPC_W-1:0] opcode;
  logic isRelCall, isRegCall, isReturn, isTrap;

  assign opcode = instr[INSTR_W-1:OPC_LSB];

  always_comb begin
    isRelCall = (opcode == OPC_CALL) && instr[11];
    isRegCall = (opcode == OPC_CALL) && !instr[11] && (instr[10:9] == 2'b00)
                && (instr[5:0] == 6'd0);
    isReturn  = (opcode == OPC_JMP) && (instr[11:9] == 3'd0)
                && (instr[8:6] == LINK_REG) && (instr[5:0] == 6'd0);
    isTrap    = (opcode == OPC_TRAP) && (instr[11:VEC_W] == '0);
  end

  always_comb begin
    strobe    = '{pcWe: 1'b0, linkWe: 1'b0, memReq: 1'b0, illegal: 1'b0, tgtSel: TGT_REL};
    stateNext = state;
    if (state == ST_VEC_WAIT) begin
      strobe.pcWe   = 1'b1;
      strobe.tgtSel = TGT_VEC;
      stateNext     = ST_IDLE;
    end else if (instrValid) begin
      if (isRelCall) begin
        strobe.pcWe   = 1'b1;
        strobe.linkWe = 1'b1;
        strobe.tgtSel = TGT_REL;
      end else if (isRegCall) begin
        strobe.pcWe   = 1'b1;
        strobe.linkWe = 1'b1;
        strobe.tgtSel = TGT_REG;
      end else if (isReturn) begin
        strobe.pcWe   = 1'b1;
        strobe.tgtSel = TGT_REG;
      end else if (isTrap) begin
        strobe.linkWe = 1'b1;
        strobe.memReq = 1'b1;
        stateNext     = ST_VEC_WAIT;
      end else begin
        strobe.illegal = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_VEC_WAIT);
endmodule

// File: rtl/ctu_datapath.sv
`timescale 1ns/1ps
module ctu_datapath
  import ctu_pkg::*;
(
  input  xferStrobe_t       strobe,
  input  logic [OFF_W-1:0]  offField,
  input  logic [RIDX_W-1:0] baseField,
  input  logic [VEC_W-1:0]  vecField,
  input  logic [ADDR_W-1:0] pcInc,
  input  logic [ADDR_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [RIDX_W-1:0] regRdAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] linkData
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam int PAD_W = ADDR_W - VEC_W;

  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] relTarget;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offExt = {{EXT_W{offField[OFF_W-1]}}, offField};
    end else begin : g_nosext
      assign offExt = offField[ADDR_W-1:0];
    end
  endgenerate

  assign relTarget = pcInc + offExt;
  assign regRdAddr = baseField;
  assign memRdAddr = {{PAD_W{1'b0}}, vecField};
  assign linkData  = pcInc;

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_REG: nextPc = regRdData;
      TGT_VEC: nextPc = memRdData;
      default: nextPc = relTarget;
    endcase
  end
endmodule

// File: rtl/ctrl_xfer_unit.sv
`timescale 1ns/1ps
module ctrl_xfer_unit
  import ctu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [ADDR_W-1:0]   pcInc,
  input  logic [ADDR_W-1:0]   regRdData,
  input  logic [ADDR_W-1:0]   memRdData,
  output logic [RIDX_W-1:0]   regRdAddr,
  output logic                memRdReq,
  output logic [ADDR_W-1:0]   memRdAddr,
  output logic                pcWe,
  output logic [ADDR_W-1:0]   nextPc,
  output logic                linkWe,
  output logic [ADDR_W-1:0]   linkData,
  output logic                illegal,
  output logic                busy
);
  xferStrobe_t strobe;

  ctu_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instr      (instr),
    .strobe     (strobe),
    .busy       (busy)
  );

  ctu_datapath u_datapath (
    .strobe     (strobe),
    .offField   (instr[OFF_W-1:0]),
    .baseField  (instr[8:6]),
    .vecField   (instr[VEC_W-1:0]),
    .pcInc      (pcInc),
    .regRdData  (regRdData),
    .memRdData  (memRdData),
    .regRdAddr  (regRdAddr),
    .memRdAddr  (memRdAddr),
    .nextPc     (nextPc),
    .linkData   (linkData)
  );

  assign pcWe     = strobe.pcWe;
  assign linkWe   = strobe.linkWe;
  assign memRdReq = strobe.memReq;
  assign illegal  = strobe.illegal;
endmodule

// File: rtl/ctu_checker.sv
`timescale 1ns/1ps
module ctu_checker
  import ctu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [ADDR_W-1:0] pcInc,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              pcWe,
  input logic              linkWe,
  input logic [ADDR_W-1:0] linkData,
  input logic              illegal,
  input logic              busy
);
  p_trap_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> (busy && pcWe));

  p_trap_issue_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (!pcWe && memRdAddr[ADDR_W-1:VEC_W] == '0));

  p_busy_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!memRdReq && !linkWe && !illegal));

  p_link_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkData == pcInc));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!pcWe && !linkWe && !memRdReq));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!instrValid && !busy) |-> (!pcWe && !linkWe && !memRdReq && !illegal));
endmodule

bind ctrl_xfer_unit ctu_checker u_chk (.*);

// File: tb/ctrl_xfer_unit_test.sv
`timescale 1ns/1ps
module ctrl_xfer_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [15:0] pcInc = 16'h0000;
  logic [15:0] regRdData;
  logic [15:0] memRdData = 16'h0000;
  logic [2:0]  regRdAddr;
  logic        memRdReq;
  logic [15:0] memRdAddr;
  logic        pcWe;
  logic [15:0] nextPc;
  logic        linkWe;
  logic [15:0] linkData;
  logic        illegal;
  logic        busy;

  logic [15:0] regs [8];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ctrl_xfer_unit uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .pcInc(pcInc), .regRdData(regRdData), .memRdData(memRdData),
    .regRdAddr(regRdAddr), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .pcWe(pcWe), .nextPc(nextPc), .linkWe(linkWe), .linkData(linkData),
    .illegal(illegal), .busy(busy)
  );

  assign regRdData = regs[regRdAddr];

  function automatic logic [15:0] tableWord(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h1234;
  endfunction

  // bench register file and vector table
  always @(posedge clk) begin
    if (linkWe) regs[7] <= linkData;
    if (memRdReq) memRdData <= tableWord(memRdAddr);
  end

  // 1 rel call, 2 reg call, 3 return, 4 trap, 0 illegal
  function automatic int classify(input logic [15:0] w);
    if (w[15:12] == 4'h4 && w[11]) return 1;
    if (w[15:11] == 5'b01000 && w[10:9] == 2'b00 && w[5:0] == 6'd0) return 2;
    if (w == 16'hC1C0) return 3;
    if (w[15:8] == 8'hF0) return 4;
    return 0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    check(req, "pcWe", {15'd0, pcWe}, 16'd0);
    check(req, "linkWe", {15'd0, linkWe}, 16'd0);
    check(req, "memRdReq", {15'd0, memRdReq}, 16'd0);
  endtask

  // present one word for one cycle, check it, and follow a trap through
  task automatic issue(input logic [15:0] w, input logic [15:0] pc);
    int kind;
    logic [15:0] expPc;
    @(negedge clk);
    instrValid = 1'b1; instr = w; pcInc = pc;
    #2;
    kind = classify(w);
    case (kind)
      1: begin
        expPc = pc + {{5{w[10]}}, w[10:0]};
        check("R1", "pcWe", {15'd0, pcWe}, 16'd1);
        check("R1", "nextPc", nextPc, expPc);
        check("R3", "linkWe", {15'd0, linkWe}, 16'd1);
        check("R3", "linkData", linkData, pc);
      end
      2: begin
        check("R2", "regRdAddr", {13'd0, regRdAddr}, {13'd0, w[8:6]});
        check("R2", "pcWe", {15'd0, pcWe}, 16'd1);
        check("R2", "nextPc", nextPc, regs[w[8:6]]);
        check("R3", "linkWe", {15'd0, linkWe}, 16'd1);
        check("R3", "linkData", linkData, pc);
      end
      3: begin
        check("R4", "regRdAddr", {13'd0, regRdAddr}, 16'd7);
        check("R4", "pcWe", {15'd0, pcWe}, 16'd1);
        check("R4", "nextPc", nextPc, regs[7]);
        check("R3", "linkWe on return", {15'd0, linkWe}, 16'd0);
      end
      4: begin
        check("R5", "memRdReq", {15'd0, memRdReq}, 16'd1);
        check("R5", "memRdAddr", memRdAddr, {8'h00, w[7:0]});
        check("R5", "pcWe first cycle", {15'd0, pcWe}, 16'd0);
        check("R3", "linkWe", {15'd0, linkWe}, 16'd1);
        check("R3", "linkData", linkData, pc);
        @(negedge clk);
        instrValid = 1'b1; instr = 16'($urandom); pcInc = 16'($urandom);
        #2;
        check("R5", "busy", {15'd0, busy}, 16'd1);
        check("R5", "pcWe second cycle", {15'd0, pcWe}, 16'd1);
        check("R5", "nextPc", nextPc, tableWord({8'h00, w[7:0]}));
        check("R6", "linkWe busy", {15'd0, linkWe}, 16'd0);
        check("R6", "memRdReq busy", {15'd0, memRdReq}, 16'd0);
        check("R6", "illegal busy", {15'd0, illegal}, 16'd0);
      end
      default: begin
        check("R8", "illegal", {15'd0, illegal}, 16'd1);
        quiet("R8");
      end
    endcase
    if (kind != 0 && kind != 4) check("R8", "illegal on legal", {15'd0, illegal}, 16'd0);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    instrValid = 1'b0; instr = 16'($urandom); pcInc = 16'($urandom);
    #2;
    check("R9", "busy idle", {15'd0, busy}, 16'd0);
    check("R9", "illegal idle", {15'd0, illegal}, 16'd0);
    quiet("R9");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    #2;
    check("R9", "busy in reset", {15'd0, busy}, 16'd0);
    rstN = 1'b1;
    idleCycle();

    // directed corners
    issue(16'h4C00, 16'h3000);            // R1 most negative offset
    issue(16'h4BFF, 16'hFF00);            // R1 most positive offset, wraps
    @(negedge clk); regs[7] = 16'hABCD;
    issue(16'h41C0, 16'h5555);            // R7: register call via R7
    idleCycle();
    check("R7", "link after call", regs[7], 16'h5555);
    issue(16'hC1C0, 16'h1111);            // R4 return to 0x5555
    issue(16'hF000, 16'h2000);            // R5 vector 0x00
    issue(16'hF0FF, 16'h2002);            // R5 vector 0xFF
    issue(16'hF125, 16'h2004);            // R8 trap with nonzero bits 11:8
    issue(16'hC180, 16'h2006);            // R8 jump through R6, not a return
    issue(16'h4201, 16'h2008);            // R8 register call with stray bits
    issue(16'h1234, 16'h200A);            // R8 other opcode
    idleCycle();

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] w;
      int sel;
      sel = int'($urandom_range(0, 6));
      case (sel)
        0: w = {5'b01001, 11'($urandom)};
        1: w = {7'b0100000, 3'($urandom), 6'd0};
        2: w = 16'hC1C0;
        3: w = {8'hF0, 8'($urandom)};
        default: w = 16'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        regs[3'($urandom)] = 16'($urandom);
      end
      if ($urandom_range(0, 4) == 0) idleCycle();
      issue(w, 16'($urandom));
    end
    idleCycle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule